// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that moves captured data into memory by walking a linked list of descriptors. A start strobe hands the channel the address of the first descriptor. The channel reads that descriptor from a small descriptor memory. It then drains the number of 64-bit beats named in the descriptor from a capture FIFO and writes them to consecutive target addresses. After that it follows the descriptor's next-address field to the next descriptor. The walk ends when a descriptor's next address is the stop marker.

The descriptors alone control the chaining. A descriptor with a zero command word moves nothing and only redirects the walk, so the chain of one buffer can jump to the first descriptor of another. A flag in each command word asks for an end interrupt once that descriptor has finished. Every descriptor is read afresh each time the walk reaches it. Software can therefore turn a terminating descriptor into a link while the channel runs, as long as the change lands before the channel fetches that descriptor.

The controller is a five-state machine:
- IDLE waits for start.
- FETCH issues the descriptor read.
- LATCH captures the returned descriptor.
- MOVE transfers beats.
- ADVANCE loads the next address.

The transitions are:
- IDLE→FETCH on start with a non-stop address.
- IDLE→IDLE on start with the stop address.
- FETCH→LATCH always.
- LATCH→MOVE when the beat count is non-zero.
- LATCH→ADVANCE when the beat count is zero.
- MOVE→ADVANCE on the last beat handshake.
- ADVANCE→FETCH when the next address is not the stop value.
- ADVANCE→IDLE when it is.

Top module: `dchain_dma`

## Requirements
- R1: After reset `running`, `end_irq`, `wr_en` and `desc_rd_en` are 0 and `cur_addr` is all ones.
- R2: A descriptor word is {next[DADDR_W], cmd[31:0], target[TADDR_W]}, with target in the low bits. The descriptor port returns data one cycle after `desc_rd_en`. For a descriptor of N beats, the channel writes N beats to target, target+8, and so on, carrying the FIFO words in arrival order.
- R3: When command bit 21 is set, `end_irq` rises once that descriptor completes. It stays high until `irq_ack` is pulsed. A chain whose descriptors all have bit 21 clear leaves `end_irq` at 0.
- R4: A descriptor whose command word is zero performs no write, and the walk continues at its next address.
- R5: A next address of all ones ends the chain. `cur_addr` then reads all ones, and `running` falls in the same cycle that this value appears on `cur_addr`.
- R6: The byte count is command bits [12:0], and its low three bits are dropped, so 21 bytes gives 2 beats.
- R7: A beat is written only in a cycle where `fifo_valid` and `fifo_ready` are both high. When the FIFO stalls, the data and addresses are unchanged.
- R8: A descriptor is read from memory each time the walk reaches it. A stop descriptor rewritten into a link before its fetch is followed.
- R9: A start strobe while `running` is high has no effect on the writes or on the chain being walked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start strobe, used only while idle |
| start_addr | input | DADDR_W | First descriptor address |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_addr | output | DADDR_W | Descriptor read address |
| desc_rd_data | input | DADDR_W+32+TADDR_W | Descriptor word, one cycle after the request |
| fifo_valid | input | 1 | FIFO has a beat |
| fifo_data | input | DATA_W | FIFO beat |
| fifo_ready | output | 1 | Channel accepts a beat |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | TADDR_W | Memory byte address |
| wr_data | output | DATA_W | Memory write data |
| cur_addr | output | DADDR_W | Address of the descriptor being processed |
| end_irq | output | 1 | End interrupt level |
| irq_ack | input | 1 | Write-one-to-clear of end_irq |
| running | output | 1 | Channel active |

## Verification
The hot-link case rewrites the stop descriptor of a running chain into a link while the channel is still in an earlier descriptor. A design that cached descriptors or prefetched ahead would miss the added buffer and leave its memory unwritten.

A zero-command redirect sits between two buffers. A design that treated it as a transfer would write to its unused target field or consume FIFO beats.

A start strobe in mid-run tests that the channel does not restart, which would re-walk or jump chains and shift the write count. A 21-byte descriptor checks that the count is rounded down. A toggling FIFO valid checks that stalled cycles neither skip nor duplicate beats.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    localparam int CMD_W      = 32;
    localparam int BYTES_MSB  = 12;
    localparam int BEAT_SHIFT = 3;
    localparam int IEN_BIT    = 21;
    localparam int BEAT_CNT_W = BYTES_MSB + 1 - BEAT_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_MOVE,
        ST_ADVANCE
    } walk_state_t;
endpackage

// File: rtl/dchain_mover.sv
module dchain_mover #(
    parameter int TADDR_W = 16,
    parameter int CNT_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_beats,
    input  logic [TADDR_W-1:0] load_addr,
    input  logic               active,
    input  logic               fifo_valid,
    output logic               fifo_ready,
    output logic               wr_en,
    output logic [TADDR_W-1:0] wr_addr,
    output logic               last_beat
);
    localparam logic [TADDR_W-1:0] BEAT_BYTES = TADDR_W'(8);

    logic [CNT_W-1:0]   left_q;
    logic [TADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            left_q <= load_beats;
            addr_q <= load_addr;
        end else if (wr_en) begin
            left_q <= left_q - 1'b1;
            addr_q <= addr_q + BEAT_BYTES;
        end
    end

    always_comb begin
        fifo_ready = active;
        wr_en      = active && fifo_valid;
        wr_addr    = addr_q;
        last_beat  = wr_en && (left_q == CNT_W'(1));
    end

    // R2: the move phase never runs with no beats left
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (left_q != '0));
endmodule

// File: rtl/dchain_irq.sv
module dchain_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic level
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   level <= 1'b0;
        else if (set) level <= 1'b1;
        else if (ack) level <= 1'b0;
    end

    // R3: the level holds until acknowledged
    p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level && !ack) |=> level);
endmodule

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
    import dchain_pkg::*;
#(
    parameter int DADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DADDR_W-1:0] start_addr,
    input  logic [DADDR_W-1:0] d_next,
    input  logic               d_ien,
    input  logic               d_empty,
    input  logic               mv_last,
    output logic               desc_rd_en,
    output logic [DADDR_W-1:0] desc_rd_addr,
    output logic               mv_load,
    output logic               mv_active,
    output logic               irq_set,
    output logic [DADDR_W-1:0] cur_addr,
    output logic               running
);
    localparam logic [DADDR_W-1:0] STOP_ADDR = '1;

    walk_state_t        state_q, state_d;
    logic [DADDR_W-1:0] cur_q, next_q;
    logic               ien_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start && start_addr != STOP_ADDR) state_d = ST_FETCH;
            ST_FETCH:   state_d = ST_LATCH;
            ST_LATCH:   state_d = d_empty ? ST_ADVANCE : ST_MOVE;
            ST_MOVE:    if (mv_last) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = (next_q == STOP_ADDR) ? ST_IDLE : ST_FETCH;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= STOP_ADDR;
            next_q  <= STOP_ADDR;
            ien_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) cur_q <= start_addr;
            if (state_q == ST_ADVANCE)       cur_q <= next_q;
            if (state_q == ST_LATCH) begin
                next_q <= d_next;
                ien_q  <= d_ien;
            end
        end
    end

    always_comb begin
        desc_rd_en   = (state_q == ST_FETCH);
        desc_rd_addr = cur_q;
        mv_load      = (state_q == ST_LATCH);
        mv_active    = (state_q == ST_MOVE);
        irq_set      = (state_q == ST_ADVANCE) && ien_q;
        cur_addr     = cur_q;
        running      = (state_q != ST_IDLE);
    end

    // R5: when the channel goes idle the current address is the stop value
    p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> (cur_addr == STOP_ADDR));
    // R8: a fetch is never issued for the stop value
    p_fetch_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_en |-> (desc_rd_addr != STOP_ADDR));
    // R9: a start during a run does not move the current address
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && running && state_q != ST_ADVANCE) |=> $stable(cur_addr));
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
    import dchain_pkg::*;
#(
    parameter int DADDR_W = 6,
    parameter int TADDR_W = 16,
    parameter int DATA_W  = 64,
    localparam int DESC_W = DADDR_W + CMD_W + TADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DADDR_W-1:0] start_addr,
    output logic               desc_rd_en,
    output logic [DADDR_W-1:0] desc_rd_addr,
    input  logic [DESC_W-1:0]  desc_rd_data,
    input  logic               fifo_valid,
    input  logic [DATA_W-1:0]  fifo_data,
    output logic               fifo_ready,
    output logic               wr_en,
    output logic [TADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic [DADDR_W-1:0] cur_addr,
    output logic               end_irq,
    input  logic               irq_ack,
    output logic               running
);
    logic [TADDR_W-1:0]    d_target;
    logic [CMD_W-1:0]      d_cmd;
    logic [DADDR_W-1:0]    d_next;
    logic [BEAT_CNT_W-1:0] d_beats;
    logic                  d_ien, d_empty;
    logic                  mv_load, mv_active, mv_last, irq_set;

    always_comb begin
        d_target = desc_rd_data[TADDR_W-1:0];
        d_cmd    = desc_rd_data[TADDR_W +: CMD_W];
        d_next   = desc_rd_data[TADDR_W+CMD_W +: DADDR_W];
        d_beats  = d_cmd[BYTES_MSB:BEAT_SHIFT];
        d_ien    = d_cmd[IEN_BIT];
        d_empty  = (d_beats == '0);
        wr_data  = fifo_data;
    end

    dchain_ctrl #(.DADDR_W(DADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .d_next(d_next), .d_ien(d_ien), .d_empty(d_empty), .mv_last(mv_last),
        .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr),
        .mv_load(mv_load), .mv_active(mv_active), .irq_set(irq_set),
        .cur_addr(cur_addr), .running(running)
    );

    dchain_mover #(.TADDR_W(TADDR_W), .CNT_W(BEAT_CNT_W)) u_mover (
        .clk(clk), .rst_n(rst_n), .load(mv_load), .load_beats(d_beats),
        .load_addr(d_target), .active(mv_active), .fifo_valid(fifo_valid),
        .fifo_ready(fifo_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .last_beat(mv_last)
    );

    dchain_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .ack(irq_ack), .level(end_irq)
    );

    // R2: memory writes happen only while the channel runs
    p_wr_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> running);
    // R7: a write always carries an accepted FIFO beat
    p_wr_handshake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fifo_valid && fifo_ready));
endmodule

// File: tb/dchain_dma_tb.sv
module dchain_dma_tb;
    localparam int DADDR_W = 6;
    localparam int TADDR_W = 16;
    localparam int DATA_W  = 64;
    localparam int DESC_W  = DADDR_W + 32 + TADDR_W;
    localparam logic [DADDR_W-1:0] STOP = '1;
    localparam logic [31:0] TAG = 32'hC0DE_0000;

    logic clk = 0, rst_n = 0, start = 0, irq_ack = 0;
    logic [DADDR_W-1:0] start_addr = '0;
    logic desc_rd_en, fifo_ready, wr_en, end_irq, running;
    logic [DADDR_W-1:0] desc_rd_addr, cur_addr;
    logic [DESC_W-1:0] desc_rd_data;
    logic fifo_valid;
    logic [DATA_W-1:0] fifo_data, wr_data;
    logic [TADDR_W-1:0] wr_addr;

    logic [DESC_W-1:0] dmem [0:63];
    logic [DATA_W-1:0] sink [0:511];
    logic [31:0] seq = 0;
    int wr_cnt = 0;
    bit bp_mode = 0, tgl = 0, prev_run = 0;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    dchain_dma #(.DADDR_W(DADDR_W), .TADDR_W(TADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cur_addr(cur_addr),
        .end_irq(end_irq), .irq_ack(irq_ack), .running(running)
    );

    assign fifo_valid = bp_mode ? tgl : 1'b1;
    assign fifo_data  = {TAG, seq};

    initial begin
        for (int i = 0; i < 512; i++) sink[i] = '0;
        for (int i = 0; i < 64; i++) dmem[i] = '0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tgl <= ~tgl;
        if (desc_rd_en) desc_rd_data <= dmem[desc_rd_addr];
        if (fifo_valid && fifo_ready) seq <= seq + 1;
        if (wr_en) begin
            sink[wr_addr[11:3]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R5: running must fall together with the stop value on cur_addr
    always @(negedge clk) begin
        if (rst_n && prev_run && !running)
            chk(cur_addr == STOP, "R5 stop on fall", 64'(cur_addr), 64'(STOP));
        prev_run <= running;
    end

    function automatic logic [DESC_W-1:0] mk(input logic [DADDR_W-1:0] nxt, input int bytes,
                                             input bit ien, input logic [TADDR_W-1:0] tgt);
        logic [31:0] cmd;
        cmd = '0;
        cmd[12:0] = 13'(bytes);
        cmd[21] = ien;
        return {nxt, cmd, tgt};
    endfunction

    task automatic kick(input logic [DADDR_W-1:0] a);
        @(negedge clk); start = 1; start_addr = a;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (running && t < 3000) begin @(negedge clk); t++; end
        chk(!running, req, 64'(running), 64'd0);
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    task automatic t_reset();
        chk(!running && !end_irq && !wr_en && !desc_rd_en, "R1 idle outputs",
            64'({running, end_irq, wr_en, desc_rd_en}), 64'd0);
        chk(cur_addr == STOP, "R1 cur_addr", 64'(cur_addr), 64'(STOP));
    endtask

    task automatic t_single();
        logic [31:0] b;
        b = seq;
        dmem[0] = mk(STOP, 32, 1'b1, 16'h0100);
        kick(0); wait_idle("R2 single done");
        for (int k = 0; k < 4; k++)
            chk(sink[32 + k] == {TAG, b + 32'(k)}, "R2 beat data", sink[32 + k], {TAG, b + 32'(k)});
        chk(cur_addr == STOP, "R5 cur_addr stop", 64'(cur_addr), 64'(STOP));
        @(negedge clk);
        chk(end_irq, "R3 irq set", 64'(end_irq), 64'd1);
        ack_irq();
        chk(!end_irq, "R3 irq ack", 64'(end_irq), 64'd0);
    endtask

    task automatic t_redirect();
        logic [31:0] b;
        int w0;
        b = seq; w0 = wr_cnt;
        dmem[1] = mk(6'd2, 16, 1'b0, 16'h0200);
        dmem[2] = mk(6'd3, 0, 1'b0, 16'h0F00);
        dmem[3] = mk(STOP, 8, 1'b0, 16'h0300);
        kick(1); wait_idle("R4 chain done");
        chk(wr_cnt - w0 == 3, "R4 write count", 64'(wr_cnt - w0), 64'd3);
        chk(sink[480] == 0, "R4 no redirect write", sink[480], 64'd0);
        chk(sink[96] == {TAG, b + 32'd2}, "R4 follows link", sink[96], {TAG, b + 32'd2});
        chk(!end_irq, "R3 no irq without flag", 64'(end_irq), 64'd0);
    endtask

    task automatic t_round();
        int w0;
        w0 = wr_cnt;
        dmem[4] = mk(STOP, 21, 1'b0, 16'h0900);
        kick(4); wait_idle("R6 done");
        chk(wr_cnt - w0 == 2, "R6 rounded count", 64'(wr_cnt - w0), 64'd2);
        chk(sink[290] == 0, "R6 no third beat", sink[290], 64'd0);
    endtask

    task automatic t_backpressure();
        logic [31:0] b;
        b = seq;
        bp_mode = 1;
        dmem[5] = mk(STOP, 40, 1'b0, 16'h0280);
        kick(5); wait_idle("R7 done");
        bp_mode = 0;
        for (int k = 0; k < 5; k++)
            chk(sink[80 + k] == {TAG, b + 32'(k)}, "R7 stalled data", sink[80 + k], {TAG, b + 32'(k)});
    endtask

    task automatic t_hotlink();
        logic [31:0] b;
        int w0, t;
        b = seq; w0 = wr_cnt; t = 0;
        dmem[10] = mk(6'd11, 64, 1'b0, 16'h0600);
        dmem[11] = mk(STOP, 8, 1'b0, 16'h0700);
        dmem[12] = mk(STOP, 8, 1'b1, 16'h0780);
        kick(10);
        while (wr_cnt == w0 && t < 100) begin @(negedge clk); t++; end
        dmem[11] = mk(6'd12, 8, 1'b0, 16'h0700);
        wait_idle("R8 done");
        chk(sink[240] == {TAG, b + 32'd9}, "R8 linked buffer", sink[240], {TAG, b + 32'd9});
        @(negedge clk);
        chk(end_irq, "R8 irq of linked desc", 64'(end_irq), 64'd1);
        ack_irq();
    endtask

    task automatic t_restart();
        int w0, t;
        w0 = wr_cnt; t = 0;
        dmem[20] = mk(STOP, 64, 1'b0, 16'h0800);
        dmem[21] = mk(STOP, 8, 1'b0, 16'h0A00);
        kick(20);
        while (wr_cnt - w0 < 2 && t < 100) begin @(negedge clk); t++; end
        kick(21);
        wait_idle("R9 done");
        chk(wr_cnt - w0 == 8, "R9 write count", 64'(wr_cnt - w0), 64'd8);
        chk(sink[320] == 0, "R9 other chain untouched", sink[320], 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_single();
        t_redirect();
        t_round();
        t_backpressure();
        t_hotlink();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        chk(1'b0, "watchdog", 64'(cyc), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule